// File: doc/BRIEF.md
# Machine Check Interrupt Entry

This block decides whether a machine-check error becomes an interrupt. Two error sources feed it: the instruction fetch path, which reports the faulting fetch address, and the data access path, which reports the address of the next sequential instruction. A sticky fetch-error flag in a syndrome register records every fetch-side error, even while machine checks are masked. Interrupt entry happens only when a fresh event arrives while the machine-check enable bit of the machine state register is set. A stale flag left over from a masked period never causes entry.

On entry the block saves a return address and the old machine state into two save registers. It clears a fixed group of state bits and signals a redirect in the same cycle as the event. The handler target is the vector base halfword followed by the low halfword 0x0200. Software can write the state and syndrome registers through plain write ports. The updated registers appear on the outputs one clock after the event.

Top module: `mchk_entry`

## Requirements
- R1: After reset, the state, syndrome, save-address and save-state registers read zero and `redirect` is low.
- R2: A fetch error (`ifetch_err`=1) sets syndrome bit 31 on the next clock even when state bit 12 (machine-check enable) is 0. The other syndrome bits are kept, no redirect occurs, and the state and save registers do not change.
- R3: A data error while state bit 12 is 0 has no effect on any register and raises no redirect.
- R4: When state bit 12 is 1 and syndrome bit 31 is already set, no redirect occurs in a cycle without a new error.
- R5: A fetch error while state bit 12 is 1 raises `redirect` in the same cycle. On the next clock the save address holds `ifetch_addr` and the syndrome is exactly 32'h8000_0000.
- R6: A data error alone while state bit 12 is 1 raises `redirect`. On the next clock the save address holds `next_pc`, and the syndrome is unchanged by hardware.
- R7: On any entry, the save-state register receives the full state value from the cycle of the event.
- R8: On entry, the state becomes the prior state with bits 18, 17, 15, 14, 12, 10, 9, 5 and 4 cleared (mask 32'h0006_D630). All other bits are kept.
- R9: While `redirect` is high, `redirect_pc` equals {`vec_base`, 16'h0200}.
- R10: If both errors arrive together while state bit 12 is 1, the fetch error wins: the save address holds `ifetch_addr`, the syndrome is 32'h8000_0000, and the data event is dropped.
- R11: A software syndrome write with no fetch error loads the written value. With a fetch error in the same cycle, bit 31 ends set regardless of the written value.
- R12: A software state write loads the written value on the next clock, unless an entry happens in that cycle. In that case the entry result from R8 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifetch_err | input | 1 | Fetch-side machine-check strobe |
| ifetch_addr | input | 32 | Address of the failing fetch |
| data_err | input | 1 | Data-side machine-check strobe |
| next_pc | input | 32 | Address of the next sequential instruction |
| vec_base | input | 16 | Upper halfword of the handler vector |
| sw_state_we | input | 1 | Software write strobe for the state register |
| sw_state_wdata | input | 32 | Software write value for the state register |
| sw_syn_we | input | 1 | Software write strobe for the syndrome register |
| sw_syn_wdata | input | 32 | Software write value for the syndrome register |
| redirect | output | 1 | Interrupt entry taken this cycle |
| redirect_pc | output | 32 | Handler target address |
| state_q | output | 32 | Machine state register |
| syndrome_q | output | 32 | Exception syndrome register |
| save_addr_q | output | 32 | Saved return address |
| save_state_q | output | 32 | Saved prior machine state |

## Verification
Two pairs of functions can land in the same cycle. A software syndrome write can meet a hardware fetch-error set, and a software state write can meet an interrupt entry. Both pairs are provoked by driving the write strobe and the error strobe on the same clock. The bench checks that the hardware result wins: bit 31 stays set, or the state is the masked prior value rather than the written one. A third same-cycle case drives both error sources together, and the bench checks that the saved address is the fetch address.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int unsigned XLEN = 32;

  // machine state bit positions (LSB numbering)
  localparam int unsigned ST_WAIT     = 18;
  localparam int unsigned ST_CRIT     = 17;
  localparam int unsigned ST_EXT      = 15;
  localparam int unsigned ST_USER     = 14;
  localparam int unsigned ST_MCE      = 12;
  localparam int unsigned ST_DBGWAIT  = 10;
  localparam int unsigned ST_DBG      = 9;
  localparam int unsigned ST_IRELOC   = 5;
  localparam int unsigned ST_DRELOC   = 4;

  // syndrome flag for a fetch-side machine check
  localparam int unsigned SYN_IFETCH  = 31;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_IFETCH = 2'd1,
    SRC_DATA   = 2'd2
  } mc_src_e;

  function automatic logic [XLEN-1:0] entry_clear_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[ST_WAIT]    = 1'b1;
    m[ST_CRIT]    = 1'b1;
    m[ST_EXT]     = 1'b1;
    m[ST_USER]    = 1'b1;
    m[ST_MCE]     = 1'b1;
    m[ST_DBGWAIT] = 1'b1;
    m[ST_DBG]     = 1'b1;
    m[ST_IRELOC]  = 1'b1;
    m[ST_DRELOC]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mchk_select.sv
module mchk_select
  import mchk_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  logic              ifetch_err,
  input  logic              data_err,
  input  logic              mce,
  input  logic [DATA_W-1:0] ifetch_addr,
  input  logic [DATA_W-1:0] next_pc,
  output mc_src_e           src,
  output logic              take,
  output logic [DATA_W-1:0] ret_addr
);
  // fetch side has priority; a losing data event is dropped
  always_comb begin
    src      = SRC_NONE;
    ret_addr = '0;
    if (mce) begin
      if (ifetch_err) begin
        src      = SRC_IFETCH;
        ret_addr = ifetch_addr;
      end else if (data_err) begin
        src      = SRC_DATA;
        ret_addr = next_pc;
      end
    end
  end

  assign take = (src != SRC_NONE);
endmodule

// File: rtl/mchk_vector.sv
module mchk_vector #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PREFIX_W = 16,
  parameter logic [DATA_W-PREFIX_W-1:0] VEC_OFFSET = 'h200
) (
  input  logic [PREFIX_W-1:0] base,
  output logic [DATA_W-1:0]   target
);
  localparam int unsigned LOW_W = DATA_W - PREFIX_W;

  always_comb begin
    target              = '0;
    target[LOW_W-1:0]   = VEC_OFFSET;
    target[DATA_W-1:LOW_W] = base;
  end
endmodule

// File: rtl/mchk_syndrome.sv
module mchk_syndrome #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FLAG_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_set,
  input  logic              hw_entry,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] syn_q
);
  localparam logic [DATA_W-1:0] FLAG = DATA_W'(1) << FLAG_BIT;

  logic [DATA_W-1:0] syn_d;
  logic [DATA_W-1:0] base;
  logic              syn_en;

  always_comb begin
    base   = sw_we ? sw_wdata : syn_q;
    syn_en = sw_we | hw_set | hw_entry;
    if (hw_entry)    syn_d = FLAG;
    else if (hw_set) syn_d = base | FLAG;
    else             syn_d = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      syn_q <= '0;
    else if (syn_en) syn_q <= syn_d;
  end

  // R2: fetch error always leaves the flag set
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> syn_q[FLAG_BIT]);
  // R5: entry leaves only the flag
  p_entry_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_entry |=> (syn_q[FLAG_BIT] && $countones(syn_q) == 1));
  // R6: no writer means no change
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_set && !hw_entry) |=> $stable(syn_q));
endmodule

// File: rtl/mchk_context.sv
module mchk_context #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MCE_BIT = 12,
  parameter logic [DATA_W-1:0] CLR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] ret_addr,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] state_q,
  output logic [DATA_W-1:0] save_addr_q,
  output logic [DATA_W-1:0] save_state_q,
  output logic              mce
);
  logic [DATA_W-1:0] state_d;
  logic              state_en;

  always_comb begin
    state_en = take | sw_we;
    if (take)       state_d = state_q & ~CLR_MASK;
    else if (sw_we) state_d = sw_wdata;
    else            state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_addr_q  <= '0;
      save_state_q <= '0;
    end else if (take) begin
      save_addr_q  <= ret_addr;
      save_state_q <= state_q;
    end
  end

  assign mce = state_q[MCE_BIT];

  // R7: prior state is preserved on entry
  p_save_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> save_state_q == $past(state_q));
  // R8: enable is off after entry
  p_mce_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !state_q[MCE_BIT]);
  // R12: plain software write lands
  p_sw_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !take) |=> state_q == $past(sw_wdata));
endmodule

// File: rtl/mchk_entry.sv
module mchk_entry
  import mchk_pkg::*;
#(
  parameter int unsigned DATA_W   = XLEN,
  parameter int unsigned PREFIX_W = 16,
  parameter int unsigned SYNC_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ifetch_err,
  input  logic [DATA_W-1:0]   ifetch_addr,
  input  logic                data_err,
  input  logic [DATA_W-1:0]   next_pc,
  input  logic [PREFIX_W-1:0] vec_base,
  input  logic                sw_state_we,
  input  logic [DATA_W-1:0]   sw_state_wdata,
  input  logic                sw_syn_we,
  input  logic [DATA_W-1:0]   sw_syn_wdata,
  output logic                redirect,
  output logic [DATA_W-1:0]   redirect_pc,
  output logic [DATA_W-1:0]   state_q,
  output logic [DATA_W-1:0]   syndrome_q,
  output logic [DATA_W-1:0]   save_addr_q,
  output logic [DATA_W-1:0]   save_state_q
);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(entry_clear_mask());
  localparam int unsigned LOW_W = DATA_W - PREFIX_W;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_W-1];

  mc_src_e           src;
  logic              take;
  logic              mce;
  logic [DATA_W-1:0] ret_addr;

  mchk_select #(.DATA_W(DATA_W)) u_select (
    .ifetch_err (ifetch_err),
    .data_err   (data_err),
    .mce        (mce),
    .ifetch_addr(ifetch_addr),
    .next_pc    (next_pc),
    .src        (src),
    .take       (take),
    .ret_addr   (ret_addr)
  );

  mchk_context #(
    .DATA_W  (DATA_W),
    .MCE_BIT (ST_MCE),
    .CLR_MASK(CLR_MASK)
  ) u_context (
    .clk         (clk),
    .rst_n       (rst_ni),
    .take        (take),
    .ret_addr    (ret_addr),
    .sw_we       (sw_state_we),
    .sw_wdata    (sw_state_wdata),
    .state_q     (state_q),
    .save_addr_q (save_addr_q),
    .save_state_q(save_state_q),
    .mce         (mce)
  );

  mchk_syndrome #(
    .DATA_W  (DATA_W),
    .FLAG_BIT(SYN_IFETCH)
  ) u_syndrome (
    .clk     (clk),
    .rst_n   (rst_ni),
    .hw_set  (ifetch_err),
    .hw_entry(src == SRC_IFETCH),
    .sw_we   (sw_syn_we),
    .sw_wdata(sw_syn_wdata),
    .syn_q   (syndrome_q)
  );

  mchk_vector #(
    .DATA_W    (DATA_W),
    .PREFIX_W  (PREFIX_W),
    .VEC_OFFSET(LOW_W'('h200))
  ) u_vector (
    .base  (vec_base),
    .target(redirect_pc)
  );

  assign redirect = take;

  // R3: masked machine checks never redirect
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !state_q[ST_MCE] |-> !redirect);
  // R4: no fresh event, no entry
  p_stale_quiet_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ifetch_err && !data_err) |-> !redirect);
  // R9: handler target layout
  p_target_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |-> (redirect_pc[LOW_W-1:0] == LOW_W'('h200) &&
                  redirect_pc[DATA_W-1:LOW_W] == vec_base));
  // R10: fetch source wins when both fire
  p_ifetch_prio_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (redirect && ifetch_err && data_err) |=> save_addr_q == $past(ifetch_addr));
endmodule

// File: tb/mchk_entry_tb.sv
module mchk_entry_tb;
  localparam logic [31:0] MASK = 32'h0006_D630;
  localparam logic [31:0] FLAG = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ifetch_err, data_err, sw_state_we, sw_syn_we;
  logic [31:0] ifetch_addr, next_pc, sw_state_wdata, sw_syn_wdata;
  logic [15:0] vec_base;
  logic        redirect;
  logic [31:0] redirect_pc, state_q, syndrome_q, save_addr_q, save_state_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // expected model
  logic [31:0] e_state, e_syn, e_sa, e_ss;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  mchk_entry u_dut (
    .clk(clk), .rst_n(rst_n),
    .ifetch_err(ifetch_err), .ifetch_addr(ifetch_addr),
    .data_err(data_err), .next_pc(next_pc), .vec_base(vec_base),
    .sw_state_we(sw_state_we), .sw_state_wdata(sw_state_wdata),
    .sw_syn_we(sw_syn_we), .sw_syn_wdata(sw_syn_wdata),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .state_q(state_q), .syndrome_q(syndrome_q),
    .save_addr_q(save_addr_q), .save_state_q(save_state_q)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected registers
  task automatic step(input logic ie, input logic [31:0] ia,
                      input logic de, input logic [31:0] npc,
                      input logic swe, input logic [31:0] swd,
                      input logic sye, input logic [31:0] syd,
                      input logic [15:0] base, input string tag);
    logic take;
    logic [31:0] b;
    @(negedge clk);
    ifetch_err = ie; ifetch_addr = ia; data_err = de; next_pc = npc;
    sw_state_we = swe; sw_state_wdata = swd;
    sw_syn_we = sye; sw_syn_wdata = syd; vec_base = base;
    #1;
    take = e_state[12] & (ie | de);
    chk(tag, "redirect", {31'd0, redirect}, {31'd0, take});
    if (take) chk(tag, "redirect_pc", redirect_pc, {base, 16'h0200});
    b = sye ? syd : e_syn;
    if (take) begin
      e_ss    = e_state;
      e_state = e_state & ~MASK;
      e_sa    = ie ? ia : npc;
      e_syn   = ie ? FLAG : b;
    end else begin
      if (swe) e_state = swd;
      e_syn = ie ? (b | FLAG) : b;
    end
    exp_q.push_back({e_state, e_syn, e_sa, e_ss});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    ifetch_err = 0; data_err = 0; sw_state_we = 0; sw_syn_we = 0;
  endtask

  // monitor: compares registers after each clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "state_q",      state_q,      e[127:96]);
        chk(t, "syndrome_q",   syndrome_q,   e[95:64]);
        chk(t, "save_addr_q",  save_addr_q,  e[63:32]);
        chk(t, "save_state_q", save_state_q, e[31:0]);
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ifetch_err = 0; data_err = 0; sw_state_we = 0; sw_syn_we = 0;
    ifetch_addr = '0; next_pc = '0; sw_state_wdata = '0; sw_syn_wdata = '0;
    vec_base = '0;
    e_state = '0; e_syn = '0; e_sa = '0; e_ss = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "state_q", state_q, 32'h0);
    chk("R1", "syndrome_q", syndrome_q, 32'h0);
    chk("R1", "save_addr_q", save_addr_q, 32'h0);
    chk("R1", "save_state_q", save_state_q, 32'h0);
    chk("R1", "redirect", {31'd0, redirect}, 32'h0);

    // R3: masked data error does nothing
    step(0, 0, 1, 32'h0000_0044, 0, 0, 0, 0, 16'h1111, "R3");
    // R2: masked fetch error only sets the flag
    step(1, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 16'h1111, "R2");
    // R11: software clears the syndrome with no event
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, 16'h1111, "R11");
    // R2: masked fetch error again, prior bits kept
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0300, 16'h1111, "R11");
    step(1, 32'h0000_2000, 0, 0, 0, 0, 0, 0, 16'h1111, "R2");
    // R12: software enables machine checks
    step(0, 0, 0, 0, 1, 32'h0006_F7F1, 0, 0, 16'h1111, "R12");
    // R4: stale flag with enable set, no event
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h1111, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h2222, "R4");
    // R5 R7 R8 R9: fetch-side entry
    step(1, 32'h0000_4ABC, 0, 0, 0, 0, 0, 0, 16'hFFF1, "R5");
    // R3: enable now cleared; data error ignored
    step(0, 0, 1, 32'h0000_9999, 0, 0, 0, 0, 16'hFFF1, "R3");
    // R6: data-side entry, syndrome untouched
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 16'h0000, "R12");
    step(0, 0, 1, 32'h2222_0004, 0, 0, 0, 0, 16'hABCD, "R6");
    // R10: both sources together
    step(0, 0, 0, 0, 1, 32'h0000_1000, 1, 32'h0000_0001, 16'h0000, "R12");
    step(1, 32'h0000_00A0, 1, 32'h0000_00B0, 0, 0, 0, 0, 16'h5A5A, "R10");
    // R12: entry wins over a software state write in the same cycle
    step(0, 0, 0, 0, 1, 32'h1234_5FFF, 0, 0, 16'h0000, "R12");
    step(0, 0, 1, 32'h0000_0C00, 1, 32'h0000_0000, 0, 0, 16'h7777, "R12");
    // R11: software clear races a masked fetch error
    step(1, 32'h0000_3000, 0, 0, 0, 0, 1, 32'h0000_0005, 16'h0000, "R11");
    // R8: entry from a state with every bit set
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 1, 32'h0000_0000, 16'h0000, "R8");
    step(1, 32'hDEAD_BEE0, 0, 0, 0, 0, 0, 0, 16'h8001, "R7");
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule